// File: doc/BRIEF.md
# Directory Contention Bit Tracker

This block models the directory side of a transactional coherence scheme for a small set of tracked lines. Each line has a one-bit contention flag, a sharer vector with one bit per core, an exclusive marker and a busy marker. Cores send read and write requests (plain read, plain write, upgrade, transactional write). While the matching completion message is outstanding the line stays busy, and later requests to it are told to retry. Each completion message carries three flags: transactional, contended and commit.

The flags on the completion decide how the contention flag changes. A contended completion sets it. A commit-time completion never lowers it. A plain non-transactional write completion clears it. Evicting a line from the directory resets it. Every grant response returns the line's current contention flag to the requester. A transactional write whose completion reports contention does not make the requester the exclusive owner. The requester joins the sharers instead, and any previous exclusive owner is kept as a sharer. This lets the write be versioned lazily while conflicts can still be detected.

All messages enter on one port, one per cycle. A combinational query port shows the state of any line.

Top module: `cbit_dir`

## Requirements
- R1: A request (op 0 read, 1 write, 2 upgrade, 3 transactional write) to a line that is not busy makes the line busy. On the next cycle it produces a grant response (`rsp_retry_o`=0) that carries the requesting core, the line and that line's contention flag as it stood when the request arrived.
- R2: A request to a busy line produces a retry response on the next cycle (`rsp_retry_o`=1) and changes no state of the line.
- R3: A completion (op 4) to a busy line with the contended flag set sets the line's contention flag.
- R4: A completion with the commit flag set and the contended flag clear leaves the contention flag unchanged, so a set flag stays at 1.
- R5: A completion that has the transactional, contended and commit flags all clear, and that finishes a pending write or upgrade, clears the contention flag.
- R6: An uncontended, non-commit completion that finishes a pending read or transactional write leaves the contention flag unchanged.
- R7: An eviction (op 5) of a line clears its contention flag, sharers, exclusive marker and busy marker.
- R8: A completed read adds the pending core to the sharers and clears the exclusive marker. A previous exclusive owner therefore stays on as a sharer.
- R9: A completed write, a completed upgrade, or a completed transactional write whose completion is uncontended leaves the pending core as the sole sharer, with the exclusive marker set.
- R10: A completed transactional write whose completion is contended ORs the pending core into the existing sharers, keeps any previous owner and leaves the exclusive marker clear. For example, sharers {1,2} become {1,2,3}.
- R11: A completion to a line that is not busy is ignored. No message changes any line other than the one it addresses.
- R12: After reset every line has contention flag 0, no sharers, and is neither exclusive nor busy. No response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message present this cycle |
| msg_op_i | input | 3 | 0 read, 1 write, 2 upgrade, 3 transactional write, 4 completion, 5 evict |
| msg_line_i | input | LW | Addressed line |
| msg_core_i | input | CW | Requesting core (used by requests) |
| ub_txn_i | input | 1 | Completion: transactional flag |
| ub_cont_i | input | 1 | Completion: contended flag |
| ub_commit_i | input | 1 | Completion: commit-time flag |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rsp_retry_o | output | 1 | 1 = retry, 0 = grant |
| rsp_cbit_o | output | 1 | Contention flag returned with the response |
| rsp_core_o | output | CW | Core the response goes to |
| rsp_line_o | output | LW | Line the response refers to |
| qry_line_i | input | LW | Line to inspect |
| qry_cbit_o | output | 1 | Contention flag of the inspected line |
| qry_sharers_o | output | N_CORES | Sharer vector of the inspected line |
| qry_excl_o | output | 1 | Exclusive marker of the inspected line |
| qry_busy_o | output | 1 | Busy marker of the inspected line |

## Verification
The bench builds the block with 16 cores and 4 lines. The full sharer vector width is therefore exercised, while eviction and isolation can be checked on a line that no message touches. One line is driven through a chain of request and completion pairs. This chain reaches each way the contention flag can be set, held or cleared, each sharer merge, and each demotion of an exclusive owner. A retry against a pending line and a stray completion show that blocked or idle lines keep their state.

// File: rtl/cbit_dir_pkg.sv
package cbit_dir_pkg;
  typedef enum logic [2:0] {
    OP_GETS  = 3'd0,
    OP_GETX  = 3'd1,
    OP_UPGR  = 3'd2,
    OP_TGETX = 3'd3,
    OP_UNBLK = 3'd4,
    OP_EVICT = 3'd5
  } op_e;
endpackage

// File: rtl/cbit_dir_next.sv
module cbit_dir_next
  import cbit_dir_pkg::*;
#(
  parameter int N_CORES = 16,
  localparam int CW = $clog2(N_CORES)
) (
  input  logic               valid_i,
  input  logic [2:0]         op_i,
  input  logic [CW-1:0]      core_i,
  input  logic               txn_i,
  input  logic               cont_i,
  input  logic               commit_i,
  input  logic               cur_cbit_i,
  input  logic [N_CORES-1:0] cur_sh_i,
  input  logic               cur_excl_i,
  input  logic               cur_busy_i,
  input  logic [CW-1:0]      cur_pcore_i,
  input  logic [2:0]         cur_pop_i,
  output logic               we_o,
  output logic               nxt_cbit_o,
  output logic [N_CORES-1:0] nxt_sh_o,
  output logic               nxt_excl_o,
  output logic               nxt_busy_o,
  output logic [CW-1:0]      nxt_pcore_o,
  output logic [2:0]         nxt_pop_o,
  output logic               rsp_fire_o,
  output logic               rsp_retry_o
);
  logic               is_req;
  logic [N_CORES-1:0] core_bit;

  assign is_req   = op_i <= 3'(OP_TGETX);
  assign core_bit = N_CORES'(1) << cur_pcore_i;

  always_comb begin
    we_o        = 1'b0;
    nxt_cbit_o  = cur_cbit_i;
    nxt_sh_o    = cur_sh_i;
    nxt_excl_o  = cur_excl_i;
    nxt_busy_o  = cur_busy_i;
    nxt_pcore_o = cur_pcore_i;
    nxt_pop_o   = cur_pop_i;
    rsp_fire_o  = 1'b0;
    rsp_retry_o = 1'b0;
    if (valid_i) begin
      if (is_req) begin
        rsp_fire_o  = 1'b1;
        rsp_retry_o = cur_busy_i;
        if (!cur_busy_i) begin
          we_o        = 1'b1;
          nxt_busy_o  = 1'b1;
          nxt_pcore_o = core_i;
          nxt_pop_o   = op_i;
        end
      end else if (op_i == 3'(OP_UNBLK)) begin
        if (cur_busy_i) begin
          we_o       = 1'b1;
          nxt_busy_o = 1'b0;
          // flag update: contended sets, commit holds, plain write clears
          if (cont_i)
            nxt_cbit_o = 1'b1;
          else if (!commit_i && !txn_i &&
                   (cur_pop_i == 3'(OP_GETX) || cur_pop_i == 3'(OP_UPGR)))
            nxt_cbit_o = 1'b0;
          // excl implies cur_sh_i is the owner bit, so OR keeps the owner
          if (cur_pop_i == 3'(OP_GETS) || (cur_pop_i == 3'(OP_TGETX) && cont_i)) begin
            nxt_sh_o   = cur_sh_i | core_bit;
            nxt_excl_o = 1'b0;
          end else begin
            nxt_sh_o   = core_bit;
            nxt_excl_o = 1'b1;
          end
        end
      end else if (op_i == 3'(OP_EVICT)) begin
        we_o       = 1'b1;
        nxt_cbit_o = 1'b0;
        nxt_sh_o   = '0;
        nxt_excl_o = 1'b0;
        nxt_busy_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cbit_dir_entry.sv
module cbit_dir_entry #(
  parameter int N_CORES = 16,
  localparam int CW = $clog2(N_CORES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               d_cbit_i,
  input  logic [N_CORES-1:0] d_sh_i,
  input  logic               d_excl_i,
  input  logic               d_busy_i,
  input  logic [CW-1:0]      d_pcore_i,
  input  logic [2:0]         d_pop_i,
  output logic               q_cbit_o,
  output logic [N_CORES-1:0] q_sh_o,
  output logic               q_excl_o,
  output logic               q_busy_o,
  output logic [CW-1:0]      q_pcore_o,
  output logic [2:0]         q_pop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_cbit_o  <= 1'b0;
      q_sh_o    <= '0;
      q_excl_o  <= 1'b0;
      q_busy_o  <= 1'b0;
      q_pcore_o <= '0;
      q_pop_o   <= '0;
    end else if (we_i) begin
      q_cbit_o  <= d_cbit_i;
      q_sh_o    <= d_sh_i;
      q_excl_o  <= d_excl_i;
      q_busy_o  <= d_busy_i;
      q_pcore_o <= d_pcore_i;
      q_pop_o   <= d_pop_i;
    end
  end

  // R9
  excl_single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_excl_o |-> $countones(q_sh_o) == 1);
endmodule

// File: rtl/cbit_dir.sv
module cbit_dir
  import cbit_dir_pkg::*;
#(
  parameter int N_CORES = 16,
  parameter int N_LINES = 8,
  localparam int CW = $clog2(N_CORES),
  localparam int LW = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  input  logic [2:0]         msg_op_i,
  input  logic [LW-1:0]      msg_line_i,
  input  logic [CW-1:0]      msg_core_i,
  input  logic               ub_txn_i,
  input  logic               ub_cont_i,
  input  logic               ub_commit_i,
  output logic               rsp_valid_o,
  output logic               rsp_retry_o,
  output logic               rsp_cbit_o,
  output logic [CW-1:0]      rsp_core_o,
  output logic [LW-1:0]      rsp_line_o,
  input  logic [LW-1:0]      qry_line_i,
  output logic               qry_cbit_o,
  output logic [N_CORES-1:0] qry_sharers_o,
  output logic               qry_excl_o,
  output logic               qry_busy_o
);
  logic               cbit_q  [N_LINES];
  logic [N_CORES-1:0] sh_q    [N_LINES];
  logic               excl_q  [N_LINES];
  logic               busy_q  [N_LINES];
  logic [CW-1:0]      pcore_q [N_LINES];
  logic [2:0]         pop_q   [N_LINES];

  logic               we, n_cbit, n_excl, n_busy, rsp_fire, rsp_retry;
  logic [N_CORES-1:0] n_sh;
  logic [CW-1:0]      n_pcore;
  logic [2:0]         n_pop;

  cbit_dir_next #(.N_CORES(N_CORES)) u_next (
    .valid_i    (msg_valid_i),
    .op_i       (msg_op_i),
    .core_i     (msg_core_i),
    .txn_i      (ub_txn_i),
    .cont_i     (ub_cont_i),
    .commit_i   (ub_commit_i),
    .cur_cbit_i (cbit_q[msg_line_i]),
    .cur_sh_i   (sh_q[msg_line_i]),
    .cur_excl_i (excl_q[msg_line_i]),
    .cur_busy_i (busy_q[msg_line_i]),
    .cur_pcore_i(pcore_q[msg_line_i]),
    .cur_pop_i  (pop_q[msg_line_i]),
    .we_o       (we),
    .nxt_cbit_o (n_cbit),
    .nxt_sh_o   (n_sh),
    .nxt_excl_o (n_excl),
    .nxt_busy_o (n_busy),
    .nxt_pcore_o(n_pcore),
    .nxt_pop_o  (n_pop),
    .rsp_fire_o (rsp_fire),
    .rsp_retry_o(rsp_retry)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    cbit_dir_entry #(.N_CORES(N_CORES)) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we && (msg_line_i == LW'(g))),
      .d_cbit_i (n_cbit),
      .d_sh_i   (n_sh),
      .d_excl_i (n_excl),
      .d_busy_i (n_busy),
      .d_pcore_i(n_pcore),
      .d_pop_i  (n_pop),
      .q_cbit_o (cbit_q[g]),
      .q_sh_o   (sh_q[g]),
      .q_excl_o (excl_q[g]),
      .q_busy_o (busy_q[g]),
      .q_pcore_o(pcore_q[g]),
      .q_pop_o  (pop_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_retry_o <= 1'b0;
      rsp_cbit_o  <= 1'b0;
      rsp_core_o  <= '0;
      rsp_line_o  <= '0;
    end else begin
      rsp_valid_o <= rsp_fire;
      if (rsp_fire) begin
        rsp_retry_o <= rsp_retry;
        rsp_cbit_o  <= cbit_q[msg_line_i];
        rsp_core_o  <= msg_core_i;
        rsp_line_o  <= msg_line_i;
      end
    end
  end

  assign qry_cbit_o    = cbit_q[qry_line_i];
  assign qry_sharers_o = sh_q[qry_line_i];
  assign qry_excl_o    = excl_q[qry_line_i];
  assign qry_busy_o    = busy_q[qry_line_i];

  logic is_req_in;
  assign is_req_in = msg_valid_i && (msg_op_i <= 3'(OP_TGETX));

  // R1
  grant_cbit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_req_in && !busy_q[msg_line_i] |=>
      rsp_valid_o && !rsp_retry_o && rsp_cbit_o == $past(cbit_q[msg_line_i])
      && busy_q[$past(msg_line_i)]);
  // R2
  retry_on_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_req_in && busy_q[msg_line_i] |=> rsp_valid_o && rsp_retry_o);
  // R3
  cont_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_op_i == 3'(OP_UNBLK) && busy_q[msg_line_i] && ub_cont_i
      |=> cbit_q[$past(msg_line_i)]);
  // R4
  commit_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_op_i == 3'(OP_UNBLK) && ub_commit_i && cbit_q[msg_line_i]
      |=> cbit_q[$past(msg_line_i)]);
  // R7
  evict_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_op_i == 3'(OP_EVICT) |=>
      !cbit_q[$past(msg_line_i)] && sh_q[$past(msg_line_i)] == '0
      && !busy_q[$past(msg_line_i)]);
endmodule

// File: tb/cbit_dir_test.sv
module cbit_dir_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;
  localparam int NL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mv = 1'b0;
  logic [2:0]  mop = '0;
  logic [1:0]  mline = '0;
  logic [3:0]  mcore = '0;
  logic        t = 1'b0, c = 1'b0, k = 1'b0;
  logic        rv, rr, rc;
  logic [3:0]  rcore;
  logic [1:0]  rline;
  logic [1:0]  qline = '0;
  logic        qc, qe, qb;
  logic [15:0] qs;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbit_dir #(.N_CORES(NC), .N_LINES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(mv), .msg_op_i(mop),
    .msg_line_i(mline), .msg_core_i(mcore), .ub_txn_i(t), .ub_cont_i(c),
    .ub_commit_i(k), .rsp_valid_o(rv), .rsp_retry_o(rr), .rsp_cbit_o(rc),
    .rsp_core_o(rcore), .rsp_line_o(rline), .qry_line_i(qline),
    .qry_cbit_o(qc), .qry_sharers_o(qs), .qry_excl_o(qe), .qry_busy_o(qb)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  line;
    logic [3:0]  core;
    logic        t, c, k;
    logic        rv, rr, rc;
    logic        cb;
    logic [15:0] sh;
    logic        ex, bz;
    logic [3:0]  req;
  } vec_t;

  // op line core t c k | rv rr rc | cbit sharers excl busy | req
  localparam vec_t VEC [23] = '{
    '{3'd0, 2'd1, 4'd1, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0,16'h0000,1'b0,1'b1, 4'd1},  // R1 read grant
    '{3'd0, 2'd1, 4'd2, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0, 1'b0,16'h0000,1'b0,1'b1, 4'd2},  // R2 retry
    '{3'd4, 2'd1, 4'd0, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0002,1'b0,1'b0, 4'd8},  // R8
    '{3'd0, 2'd1, 4'd2, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0,16'h0002,1'b0,1'b1, 4'd1},
    '{3'd4, 2'd1, 4'd0, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0006,1'b0,1'b0, 4'd8},  // R8 {1,2}
    '{3'd3, 2'd1, 4'd3, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0,16'h0006,1'b0,1'b1, 4'd1},
    '{3'd4, 2'd1, 4'd0, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b1,16'h000E,1'b0,1'b0, 4'd10}, // R10 R3
    '{3'd0, 2'd1, 4'd4, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b1,16'h000E,1'b0,1'b1, 4'd1},  // R1 flag returned
    '{3'd4, 2'd1, 4'd0, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b1,16'h001E,1'b0,1'b0, 4'd6},  // R6 read keeps
    '{3'd2, 2'd1, 4'd5, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b1,16'h001E,1'b0,1'b1, 4'd1},
    '{3'd4, 2'd1, 4'd0, 1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b1,16'h0020,1'b1,1'b0, 4'd4},  // R4 R9
    '{3'd3, 2'd1, 4'd6, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b1,16'h0020,1'b1,1'b1, 4'd1},
    '{3'd4, 2'd1, 4'd0, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b1,16'h0060,1'b0,1'b0, 4'd10}, // R10 owner kept
    '{3'd1, 2'd1, 4'd7, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b1,16'h0060,1'b0,1'b1, 4'd1},
    '{3'd4, 2'd1, 4'd0, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0080,1'b1,1'b0, 4'd5},  // R5 clears
    '{3'd4, 2'd1, 4'd0, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0080,1'b1,1'b0, 4'd11}, // R11 stray
    '{3'd3, 2'd1, 4'd0, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0,16'h0080,1'b1,1'b1, 4'd1},
    '{3'd4, 2'd1, 4'd0, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0001,1'b1,1'b0, 4'd9},  // R9 R6
    '{3'd0, 2'd1, 4'd9, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0,16'h0001,1'b1,1'b1, 4'd1},
    '{3'd4, 2'd1, 4'd0, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b1,16'h0201,1'b0,1'b0, 4'd8},  // R8 demote R3
    '{3'd5, 2'd1, 4'd0, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,1'b0, 4'd7},  // R7
    '{3'd1, 2'd1, 4'd3, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0,16'h0000,1'b0,1'b1, 4'd1},
    '{3'd5, 2'd1, 4'd0, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,1'b0, 4'd7}   // R7 busy
  };

  task automatic chk(input int req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    mv = 1'b1; mop = v.op; mline = v.line; mcore = v.core;
    t = v.t; c = v.c; k = v.k;
    @(negedge clk);
    mv = 1'b0;
    qline = v.line;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state on every line
    for (int i = 0; i < NL; i++) begin
      qline = 2'(i);
      #1;
      chk(12, "reset cbit/sh/excl/busy", {13'd0, qc, qs, qe, qb}, 32'd0);
    end
    chk(12, "reset rsp_valid", 32'(rv), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 23; i++) begin
      send(VEC[i]);
      chk(int'(VEC[i].req), $sformatf("vec %0d rsp_valid", i), 32'(rv), 32'(VEC[i].rv));
      if (VEC[i].rv) begin
        chk(int'(VEC[i].req), $sformatf("vec %0d retry", i), 32'(rr), 32'(VEC[i].rr));
        chk(int'(VEC[i].req), $sformatf("vec %0d rsp_cbit", i), 32'(rc), 32'(VEC[i].rc));
        chk(int'(VEC[i].req), $sformatf("vec %0d rsp_core/line", i),
            {26'd0, rcore, rline}, {26'd0, VEC[i].core, VEC[i].line});
      end
      chk(int'(VEC[i].req), $sformatf("vec %0d state", i),
          {13'd0, qc, qs, qe, qb},
          {13'd0, VEC[i].cb, VEC[i].sh, VEC[i].ex, VEC[i].bz});
    end

    // R11 other lines untouched
    qline = 2'd0;
    #1;
    chk(11, "line0 untouched", {13'd0, qc, qs, qe, qb}, 32'd0);

    // R2 retry leaves pending core; R3 R4 on line 2
    send('{3'd1, 2'd2, 4'd4, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0, 4'd1});
    send('{3'd0, 2'd2, 4'd9, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0, 4'd2});
    chk(2, "retry on busy line", 32'(rr), 32'd1);
    send('{3'd4, 2'd2, 4'd0, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0, 4'd3});
    chk(2, "pending core kept after retry", {16'd0, qs}, 32'h0010);
    chk(3, "contended commit sets cbit", 32'(qc), 32'd1);
    send('{3'd1, 2'd2, 4'd4, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0, 4'd1});
    chk(1, "grant carries set cbit", 32'(rc), 32'd1);
    send('{3'd4, 2'd2, 4'd0, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0, 4'd5});
    chk(5, "transactional write completion keeps cbit", 32'(qc), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule